// File: doc/BRIEF.md
# Serial Display Data Loader

This block takes a three-wire serial stream (an enable strobe, a shift clock and a data line) plus a level pin that tells command bits from display bits, and turns it into a 200-bit display image held in an output latch. The image is split into four 50-bit banks. A short command sent first picks the bank that the next display burst writes. The same command can instead join all four banks into one 200-bit chain, or blank the whole image.

All four serial inputs are brought into the system clock through two-flop synchronisers, and their edges are found on the synchronised copies. The system clock must run at least eight times faster than the shift clock. Nothing takes effect while bits arrive. Everything is applied when the enable strobe falls: the command is decoded, or the bank contents are copied to the display latch. The serial side has no back-pressure and no handshake. The sender sets the pace and must keep the strobe low for at least a few system clocks between bursts. The display output is a plain level that holds its value until the next commit.

Top module: `serial_disp_loader`

## Requirements
- R1: Bits are taken only on a rising shift-clock edge while the enable strobe is high. Shift-clock activity with the strobe low changes neither the banks nor the display.
- R2: With the mode pin high the bits form a 4-bit command, MSB first. A command burst other than the blank command leaves the display unchanged. With the mode pin low the bits are display data.
- R3: The display changes only after a falling edge of the enable strobe. It holds its value during a burst, and the new value appears within 8 system clocks of the fall.
- R4: The command, written in received order MSB..LSB, selects: 1000 bank 0 (display bits 0..49), 0100 bank 1 (bits 50..99), 1100 bank 2 (bits 100..149), 0010 bank 3 (bits 150..199), 1010 all banks as one 200-bit chain.
- R5: After a full burst, the first display bit received sits in the lowest display bit of the selected bank, or in display bit 0 in chain mode. Later bits fill upward in order.
- R6: Command 1111 writes zero into all banks and into the display latch, and leaves no bank selected.
- R7: A command burst of k<4 bits forms the code {previous code bits [3-k:0], new bits}.
- R8: A command burst of more than 4 bits uses only the last 4 bits received before the strobe falls.
- R9: A display burst of k bits, fewer than the bank width (50, or 200 in chain mode), puts those bits in the top k positions of the bank. The lower positions hold the previous bank contents moved down by k.
- R10: A display burst longer than the bank width keeps only the last 50 (or 200) bits received.
- R11: Any code other than the five listed and 1111 leaves no bank selected. Display bits sent with no bank selected are discarded, and the display keeps its value.
- R12: After reset the display and all banks read zero and no bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the shift clock |
| rst_n | input | 1 | Active-low reset |
| ce_i | input | 1 | Serial enable strobe; its falling edge commits |
| sck_i | input | 1 | Serial shift clock; bits taken on rising edge |
| sdi_i | input | 1 | Serial data |
| msel_i | input | 1 | High: command bits, low: display bits |
| disp_o | output | 200 | Latched display image, bit n drives segment element n |

## Verification
The bench goes after short and long bursts of both kinds. A design that counted bits instead of shifting would leave stale low bits or drop the last bits of an over-long burst. A design that shifted the command the wrong way would pick the wrong bank after a 2-bit or 6-bit command. Chain mode is checked with a full burst, a short burst and an over-long burst, which shows whether bits carry across bank boundaries in order. The bench also sends data with no bank selected, sends an unknown code, and toggles the shift clock with the strobe low. A loader that latched on every strobe fall or shifted outside the window would then alter the display.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_B0   = 3'd1,
    SEL_B1   = 3'd2,
    SEL_B2   = 3'd3,
    SEL_B3   = 3'd4,
    SEL_ALL  = 3'd5
  } sel_e;

  // command codes in received order, MSB first
  localparam logic [MODE_W-1:0] CODE_B0    = 4'b1000;
  localparam logic [MODE_W-1:0] CODE_B1    = 4'b0100;
  localparam logic [MODE_W-1:0] CODE_B2    = 4'b1100;
  localparam logic [MODE_W-1:0] CODE_B3    = 4'b0010;
  localparam logic [MODE_W-1:0] CODE_ALL   = 4'b1010;
  localparam logic [MODE_W-1:0] CODE_BLANK = 4'b1111;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int N     = 4,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic [DEPTH-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[DEPTH-2:0], din[i]};
      end
      assign lvl[i] = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sdl_mode_dec.sv
module sdl_mode_dec
  import sdl_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  output sel_e              sel,
  output logic              blank
);
  always_comb begin
    blank = 1'b0;
    unique case (code)
      CODE_B0:    sel = SEL_B0;
      CODE_B1:    sel = SEL_B1;
      CODE_B2:    sel = SEL_B2;
      CODE_B3:    sel = SEL_B3;
      CODE_ALL:   sel = SEL_ALL;
      CODE_BLANK: begin sel = SEL_NONE; blank = 1'b1; end
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sdl_bank.sv
module sdl_bank #(
  parameter int W = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  // new bits enter at the top so the first bit of a full burst ends at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (shift) q <= {bit_in, q[W-1:1]};
  end
endmodule

// File: rtl/serial_disp_loader.sv
module serial_disp_loader
  import sdl_pkg::*;
#(
  parameter  int BANK_W = 50,
  parameter  int N_BANK = 4,
  localparam int TOTAL  = BANK_W * N_BANK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             msel_i,
  output logic [TOTAL-1:0] disp_o
);
  localparam int IX_CE = 0, IX_SCK = 1, IX_SDI = 2, IX_MSEL = 3;

  logic [3:0] pin_lvl;
  logic ce_lvl, sck_lvl, sdi_lvl, msel_lvl;
  logic ce_d, sck_d;
  logic ce_fall, sck_rise;
  logic take_mode, take_data;
  logic win_mode, win_data;
  logic [MODE_W-1:0] mode_sr;
  sel_e sel_q, dec_sel;
  logic dec_blank, bank_clr;
  logic [TOTAL-1:0] bank_q;
  logic [TOTAL-1:0] disp_q;

  sdl_sync #(.N(4), .DEPTH(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({msel_i, sdi_i, sck_i, ce_i}),
    .lvl  (pin_lvl)
  );

  assign ce_lvl   = pin_lvl[IX_CE];
  assign sck_lvl  = pin_lvl[IX_SCK];
  assign sdi_lvl  = pin_lvl[IX_SDI];
  assign msel_lvl = pin_lvl[IX_MSEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      ce_d  <= ce_lvl;
      sck_d <= sck_lvl;
    end
  end

  assign ce_fall   = ce_d & ~ce_lvl;
  assign sck_rise  = ~sck_d & sck_lvl & ce_lvl;
  assign take_mode = sck_rise & msel_lvl;
  assign take_data = sck_rise & ~msel_lvl;

  // command shift register and window flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_sr  <= '0;
      win_mode <= 1'b0;
      win_data <= 1'b0;
    end else begin
      if (take_mode) mode_sr <= {mode_sr[MODE_W-2:0], sdi_lvl};
      if (ce_fall) begin
        win_mode <= 1'b0;
        win_data <= 1'b0;
      end else begin
        if (take_mode) win_mode <= 1'b1;
        if (take_data) win_data <= 1'b1;
      end
    end
  end

  sdl_mode_dec u_dec (
    .code (mode_sr),
    .sel  (dec_sel),
    .blank(dec_blank)
  );

  assign bank_clr = ce_fall & win_mode & dec_blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sel_q <= SEL_NONE;
    else if (ce_fall && win_mode) sel_q <= dec_sel;
  end

  // banks: each one standalone or linked into a single chain
  generate
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      logic hit, chain_bit, bit_in;
      assign hit = (sel_q == SEL_ALL) || (sel_q == sel_e'(3'(b + 1)));
      if (b == N_BANK - 1) begin : g_top
        assign chain_bit = sdi_lvl;
      end else begin : g_mid
        assign chain_bit = bank_q[(b+1)*BANK_W];
      end
      assign bit_in = (sel_q == SEL_ALL) ? chain_bit : sdi_lvl;

      sdl_bank #(.W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bank_clr),
        .shift (take_data & hit),
        .bit_in(bit_in),
        .q     (bank_q[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  // display latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          disp_q <= '0;
    else if (bank_clr)                                   disp_q <= '0;
    else if (ce_fall && win_data && sel_q != SEL_NONE)   disp_q <= bank_q;
  end

  assign disp_o = disp_q;
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
  parameter int TOTAL = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_fall,
  input logic             sck_rise,
  input logic             win_mode,
  input logic             win_data,
  input logic [3:0]       mode_sr,
  input logic [2:0]       sel,
  input logic [TOTAL-1:0] bank_q,
  input logic [TOTAL-1:0] disp_o
);
  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> $stable(disp_o));

  // R6
  blank_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && win_mode && mode_sr == 4'b1111) |=> (disp_o == '0 && bank_q == '0 && sel == 3'd0));

  // R11
  unsel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !win_mode && sel == 3'd0) |=> $stable(disp_o));

  // R1
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise && !ce_fall) |=> $stable(bank_q));

  // R2
  mode_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && win_mode && !win_data && mode_sr != 4'b1111) |=> $stable(disp_o));
endmodule

bind serial_disp_loader sdl_chk #(.TOTAL(TOTAL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_fall (ce_fall),
  .sck_rise(sck_rise),
  .win_mode(win_mode),
  .win_data(win_data),
  .mode_sr (mode_sr),
  .sel     (sel_q),
  .bank_q  (bank_q),
  .disp_o  (disp_o)
);

// File: tb/test_serial_disp_loader.sv
module test_serial_disp_loader;
  localparam int BW = 50;
  localparam int NB = 4;
  localparam int TT = BW * NB;

  typedef struct {
    logic [TT-1:0] exp;
    string         tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0, msel = 1'b0;
  logic [TT-1:0] disp;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  item_t q[$];

  // reference state
  logic [TT-1:0] m_bank = '0, m_disp = '0;
  logic [3:0]    m_code = '0;
  int            m_sel  = 0;   // 0 none, 1..4 bank, 5 chain

  always #10 clk = ~clk;

  serial_disp_loader i_serial_disp_loader (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sck_i(sck),
    .sdi_i(sdi), .msel_i(msel), .disp_o(disp)
  );

  // monitor
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      @(negedge clk);
      it = q.pop_front();
      n_cmp++;
      if (disp !== it.exp) begin
        n_bad++;
        $display("FAIL %s got %h exp %h", it.tag, disp, it.exp);
      end
    end
  end

  task automatic expect_now(input string tag);
    item_t it;
    it.exp = m_disp;
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    sdi = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (6) @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_shift(input logic b);
    if (m_sel == 5) m_bank = {b, m_bank[TT-1:1]};
    else if (m_sel != 0)
      m_bank[(m_sel-1)*BW +: BW] = {b, m_bank[(m_sel-1)*BW+1 +: BW-1]};
  endtask

  // bits sent in order bits[n-1] first (MSB first)
  task automatic send_mode(input logic [7:0] bits, input int n, input string tag);
    msel = 1'b1; ce = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      clock_bit(bits[i]);
      m_code = {m_code[2:0], bits[i]};
    end
    ce = 1'b0;
    repeat (8) @(negedge clk);
    msel = 1'b0;
    case (m_code)
      4'b1000: m_sel = 1;
      4'b0100: m_sel = 2;
      4'b1100: m_sel = 3;
      4'b0010: m_sel = 4;
      4'b1010: m_sel = 5;
      4'b1111: begin m_sel = 0; m_bank = '0; m_disp = '0; end
      default: m_sel = 0;
    endcase
    expect_now(tag);
  endtask

  // bits sent in order v[0] first
  task automatic send_data(input logic [255:0] v, input int n, input string tag);
    msel = 1'b0; ce = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      clock_bit(v[i]);
      model_shift(v[i]);
    end
    expect_now({"R3 hold before fall / ", tag});
    ce = 1'b0;
    repeat (8) @(negedge clk);
    if (m_sel != 0 && n > 0) m_disp = m_bank;
    expect_now(tag);
  endtask

  localparam logic [255:0] PA = {8{32'hA5C3_0F96}};
  localparam logic [255:0] PB = {8{32'h1357_9BDF}};
  localparam logic [255:0] PC = {8{32'hF0E1_D2C3}};
  localparam logic [255:0] PD = {8{32'h6B2E_91C4}};

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_now("R12 reset display zero");

    send_data(PA, BW, "R11 data with no bank selected discarded");

    send_mode(8'b1000, 4, "R2 command does not touch display");
    send_data(PA, BW, "R4 R5 bank0 full burst");
    send_mode(8'b0100, 4, "R4 select bank1");
    send_data(PB, BW, "R4 bank1 full burst");
    send_mode(8'b1100, 4, "R4 select bank2");
    send_data(PC, BW, "R4 bank2 full burst");
    send_mode(8'b0010, 4, "R4 select bank3");
    send_data(PD, BW, "R4 bank3 full burst");

    send_data(PB, 20, "R9 short burst bank3");
    send_mode(8'b0100, 4, "R4 reselect bank1");
    send_data(PC, 60, "R10 long burst bank1");

    // shift clock with strobe low must do nothing
    msel = 1'b0;
    for (int i = 0; i < 6; i++) clock_bit(i[0]);
    expect_now("R1 shift clock with strobe low");
    send_data(PD, 10, "R1 R9 short burst after idle clocks");

    send_mode(8'b1010, 4, "R4 select chain");
    send_data(PA ^ PD, TT, "R4 R5 chain full burst");
    send_data(PB, 37, "R9 chain short burst");
    send_data(PC, 205, "R10 chain long burst");

    send_mode(8'b1111, 4, "R6 blank all");
    send_data(PA, BW, "R6 no bank after blank");

    send_mode(8'b1000, 4, "R7 set code 1000");
    send_mode(8'b10, 2, "R7 short command gives 0010");
    send_data(PB, BW, "R7 bank3 written after short command");

    send_mode(8'b110100, 6, "R8 long command gives 0100");
    send_data(PD, BW, "R8 bank1 written after long command");

    send_mode(8'b0001, 4, "R11 unknown code");
    send_data(PC, BW, "R11 data after unknown code discarded");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule